// File: doc/BRIEF.md
# Programmable PWM Edge Timing Generator

This block drives a single PWM output whose rising and falling edges are placed at programmable tick positions inside a repeating switching period. One tick of the internal fine counter stands for one 5 ns unit of edge resolution. Eight ticks form one coarse step. The counter runs from zero up to a programmable terminal count and then wraps.

Edge times, the period and the per-edge modulation controls are written through a byte-wide register port into a shadow bank. The whole bank is copied into the active set only at the start of a period, so one period never mixes old and new settings. An external signed modulation word is sampled at the same moment.

Each edge can let that word move it later or earlier, or can ignore it. The moved edge is then clamped into the current period. The output is blanked for the whole period whenever both edges land in the same coarse step.

Top module: `pwm_edge_gen`

## Requirements
- R1: During and after reset the output is low, all shadow and active registers are zero, and the terminal count is zero, so the period is one tick long.
- R2: Register layout: addresses 0/1 hold the rise time, 2/3 the fall time, and 4/5 the terminal count. Each value is 12 bits, with the even address giving bits [11:4] and bits [7:4] of the odd address giving bits [3:0]. In the rise and fall control bytes (addresses 1 and 3), bit 3 is the modulation enable and bit 2 is the modulation sign. Writes to addresses 6 and 7 are dropped.
- R3: A write lands in the shadow bank only. The active settings and the modulation sample change only on the clock edge at which the counter wraps, and they take the shadow contents held before that edge.
- R4: The counter counts 0, 1, … up to the terminal count P, then returns to 0. A period is therefore P+1 ticks.
- R5: When the effective rise and fall times lie in different coarse steps, the output is high exactly on the ticks whose count c satisfies rise ≤ c < fall.
- R6: When the effective rise and fall times share bits [11:3] (the same 8-tick step), the output stays low for the whole period.
- R7: When the effective rise time is not below the effective fall time, the output stays low.
- R8: With an edge's enable bit at 0, the modulation word has no effect on that edge.
- R9: With the enable bit at 1, sign 0 adds the signed modulation word to the edge and sign 1 subtracts it. A larger word therefore moves a sign-1 edge earlier.
- R10: An effective edge time is clamped into the range 0 to P.
- R11: The output is never high for more than P ticks of a period, which is the period minus one tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fine tick clock, one cycle per resolution unit |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| mod_in | input | MW (8) | Signed modulation word, sampled at period start |
| pwm_out | output | 1 | PWM output |

## Verification
The bench aims at an edge pair that sits one tick short of a coarse-step boundary (47 against 40) and one that sits exactly on it (48). A design that compares full tick values, or that uses the wrong step width, would either let a 7-tick pulse through or blank an 8-tick one. It also writes an edge in the middle of a period; a design without the shadow bank would change the pulse shape partway through that period. Large modulation words on both edges push the rise time below zero and the fall time past the terminal count. Missing clamping would then wrap the arithmetic and produce a pulse that is zero, or one that is longer than the period minus one tick. The sign and enable cases catch a design that inverts the direction of the shift or that applies the word to an edge whose enable bit is off.

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen #(
  parameter int MW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           wr_addr,
  input  logic [7:0]           wr_data,
  input  logic signed [MW-1:0] mod_in,
  output logic                 pwm_out
);
  localparam int EW = 12;
  localparam int NR = 6;
  localparam int SW = EW + MW + 2;

  logic [7:0]           shadow [NR];
  logic [7:0]           active [NR];
  logic signed [MW-1:0] act_mod;
  logic [EW-1:0]        cnt;
  logic [EW-1:0]        per, rise_eff, fall_eff;
  logic                 start;

  function automatic logic [EW-1:0] place(
    input logic [EW-1:0]        base,
    input logic                 en,
    input logic                 sg,
    input logic signed [MW-1:0] m,
    input logic [EW-1:0]        lim
  );
    logic signed [SW-1:0] s, d, l;
    s = {{(SW-EW){1'b0}}, base};
    d = {{(SW-MW){m[MW-1]}}, m};
    l = {{(SW-EW){1'b0}}, lim};
    if (en) s = sg ? s - d : s + d;
    if (s < 0) return '0;
    if (s > l) return lim;
    return s[EW-1:0];
  endfunction

  assign per      = {active[4], active[5][7:4]};
  assign start    = (cnt == per);
  assign rise_eff = place({active[0], active[1][7:4]}, active[1][3], active[1][2], act_mod, per);
  assign fall_eff = place({active[2], active[3][7:4]}, active[3][3], active[3][2], act_mod, per);
  assign pwm_out  = (rise_eff[EW-1:3] != fall_eff[EW-1:3]) &&
                    (cnt >= rise_eff) && (cnt < fall_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      act_mod <= '0;
      for (int i = 0; i < NR; i++) begin
        shadow[i] <= '0;
        active[i] <= '0;
      end
    end else begin
      if (start) begin
        cnt     <= '0;
        act_mod <= mod_in;
        for (int i = 0; i < NR; i++) active[i] <= shadow[i];
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (wr_en && wr_addr < 3'(NR)) shadow[wr_addr] <= wr_data;
    end
  end
endmodule

// File: rtl/pwm_edge_gen_chk.sv
module pwm_edge_gen_chk #(
  parameter int EW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          pwm_out,
  input logic [EW-1:0] cnt,
  input logic [EW-1:0] per,
  input logic [EW-1:0] rise_eff,
  input logic [EW-1:0] fall_eff
);
  logic [EW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)       hi_cnt <= '0;
    else if (start)   hi_cnt <= '0;
    else if (pwm_out) hi_cnt <= hi_cnt + 1'b1;
  end

  assert_reset_low_R1: assert property (@(posedge clk) !rst_n |=> !pwm_out);
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n) cnt <= per);
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n) start |=> cnt == '0);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(per) && $stable(rise_eff) && $stable(fall_eff)));
  assert_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_out |-> (cnt >= rise_eff && cnt < fall_eff));
  assert_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_eff[EW-1:3] == fall_eff[EW-1:3]) |-> !pwm_out);
  assert_clamp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_eff <= per) && (fall_eff <= per));
  assert_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_out |-> hi_cnt < per);
endmodule

bind pwm_edge_gen pwm_edge_gen_chk #(.EW(12)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .pwm_out(pwm_out),
  .cnt(cnt), .per(per), .rise_eff(rise_eff), .fall_eff(fall_eff)
);

// File: tb/test_pwm_edge_gen.sv
module test_pwm_edge_gen;
  logic              clk = 0;
  logic              rst_n = 0;
  logic              wr_en = 0;
  logic [2:0]        wr_addr = 0;
  logic [7:0]        wr_data = 0;
  logic signed [7:0] mod_in = 0;
  logic              pwm_out;

  int    checks = 0, errors = 0;
  string tag = "R1";
  bit    done = 0;

  int m_cnt = 0, m_mod = 0;
  int m_sh [6] = '{default: 0};
  int m_act[6] = '{default: 0};

  pwm_edge_gen #(.MW(8)) i_pwm_edge_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mod_in(mod_in), .pwm_out(pwm_out)
  );

  always #10 clk = ~clk;

  function automatic int m_per();
    return m_act[4] * 16 + (m_act[5] >> 4);
  endfunction

  function automatic int edge_at(int hi, int ctl);
    int v = hi * 16 + (ctl >> 4);
    if ((ctl & 8) != 0) v = ((ctl & 4) != 0) ? v - m_mod : v + m_mod;
    if (v < 0) v = 0;
    if (v > m_per()) v = m_per();
    return v;
  endfunction

  function automatic bit exp_pwm();
    int r = edge_at(m_act[0], m_act[1]);
    int f = edge_at(m_act[2], m_act[3]);
    if (r / 8 == f / 8) return 0;
    return (m_cnt >= r && m_cnt < f);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_mod = 0;
      foreach (m_sh[i]) begin m_sh[i] = 0; m_act[i] = 0; end
    end else begin
      if (m_cnt == m_per()) begin
        m_cnt = 0;
        m_act = m_sh;
        m_mod = int'(mod_in);
      end else m_cnt++;
      if (wr_en && wr_addr < 6) m_sh[wr_addr] = wr_data;
    end
  end

  int hc = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (pwm_out !== exp_pwm()) begin
        errors++;
        $display("FAIL %s cnt=%0d pwm=%0b expected=%0b", tag, m_cnt, pwm_out, exp_pwm());
      end
      if (m_cnt == 0) hc = 0;
      if (pwm_out) hc++;
      checks++;
      if (hc > m_per()) begin
        errors++;
        $display("FAIL R11 width=%0d expected<=%0d", hc, m_per());
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_edges(input int r, input int rc, input int f, input int fc);
    wr(0, r >> 4); wr(1, ((r & 15) << 4) | rc);
    wr(2, f >> 4); wr(3, ((f & 15) << 4) | fc);
  endtask

  task automatic measure(input int expv, input string t);
    int s = 0;
    repeat (250) @(negedge clk);
    while (m_cnt != 0) @(negedge clk);
    for (int k = 0; k <= m_per(); k++) begin
      if (pwm_out) s++;
      @(negedge clk);
    end
    checks++;
    if (s != expv) begin
      errors++;
      $display("FAIL %s high_ticks=%0d expected=%0d", t, s, expv);
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    checks++;
    if (pwm_out !== 1'b0) begin
      errors++;
      $display("FAIL R1 pwm=%0b expected=0", pwm_out);
    end
    rst_n = 1;
    repeat (4) @(negedge clk);
    tag = "R2";
    wr(4, 8'h06); wr(5, 8'h30);
    set_edges(20, 0, 60, 0);
    measure(40, "R2 R5");
    tag = "R3";
    repeat (30) @(negedge clk);
    set_edges(10, 0, 60, 0);
    measure(50, "R3");
    wr(6, 8'hFF); wr(7, 8'hFF);
    measure(50, "R2 ignored address");
    tag = "R6";
    set_edges(40, 0, 47, 0);
    measure(0, "R6 same step");
    set_edges(40, 0, 48, 0);
    measure(8, "R6 step boundary");
    tag = "R7";
    set_edges(70, 0, 30, 0);
    measure(0, "R7");
    tag = "R8";
    mod_in = 10;
    set_edges(20, 0, 60, 0);
    measure(40, "R8");
    tag = "R9";
    set_edges(20, 8, 60, 0);
    measure(30, "R9 sign0");
    set_edges(20, 12, 60, 0);
    measure(50, "R9 sign1");
    mod_in = -5;
    set_edges(20, 0, 60, 8);
    measure(35, "R9 negative word");
    tag = "R10";
    mod_in = 100;
    set_edges(20, 12, 60, 8);
    measure(99, "R10 R11 clamp");
    repeat (20) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule